// File: doc/BRIEF.md
# Periodic Compare Timer

This block is a 10-bit up-counting timer with one compare output pin. Software sets it up through a byte-wide register port. A 3-bit source field chooses what advances the count:
- the system clock, or the system clock divided by four;
- a fast tick divided by 16 or by 64;
- a time-base tick;
- either edge of an external clock pin, taken through a two-flop synchronizer.

Every source becomes a one-cycle enable strobe in the system clock domain. All state changes happen on the system clock.

The counter clears on the first enable after it has reached a match value. That value is either the period register or the compare A register, as a control bit chooses. When the counter steps onto the compare A value, the output flop acts as programmed: it keeps its level, drives low, drives high or toggles. A polarity bit inverts what reaches the pin.

Turning the timer on clears the count and loads the output flop with a programmed starting level. Turning it off, or pausing it, freezes the count where it stands.

Top module: `periodic_cmp_timer`

## Requirements
- R1: After reset every register reads 0 and the pin is low. Register map:
  - Address 0 is control A: bit 7 = pause, bits 6:4 = source, bit 3 = on.
  - Address 1 is control B: bits 5:4 = compare action, bit 3 = starting level, bit 2 = invert, bit 0 = clear select.
  - Bits not listed for address 0 or 1 always read 0.
- R2: Each 10-bit value is read as a low byte holding bits 7:0 and a high byte holding bits 9:8 in its bits 1:0, with bits 7:2 reading 0. The pairs are: count at addresses 2/3 (read-only), compare A at 4/5, period at 6/7.
- R3: A low-byte write to compare A or period leaves the live value unchanged. The following high-byte write loads all 10 bits at once.
- R4: Source 001 advances the count on every cycle. Source 000 advances it exactly once per four cycles.
- R5: Source 010 advances once per 16 fast ticks, and source 011 once per 64 fast ticks. Sources 100 and 101 advance once per time-base tick. Without ticks the count does not move.
- R6: Source 110 advances once per rising edge of the external pin, and source 111 once per falling edge.
- R7: Writing on = 1 while the timer is off clears the count to 0 and loads the output flop with the starting level.
- R8: Writing on = 0 stops the count and keeps its value for as long as the timer stays off.
- R9: With pause = 1 the count and the output hold. Clearing pause resumes counting from the held value.
- R10: The count steps to 0 on the first enable after it equals the match target: the period when clear select is 0, compare A when it is 1.
- R11: When the count steps onto the compare A value, the output flop acts per the action field: 00 = keep, 01 = low, 10 = high, 11 = toggle. The pin is the flop inverted when the invert bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| fh_tick | input | 1 | Fast clock tick, one cycle wide |
| tbc_tick | input | 1 | Time-base tick, one cycle wide |
| ext_clk_pin | input | 1 | External clock pin, asynchronous |
| tmr_pin | output | 1 | Compare output pin |

## Verification
The bench targets the on/off edge cases:
- A design that cleared the count on turn-off, or failed to clear it on turn-on, would read a wrong count right after each control write.
- A design that let the pause write itself block the step already due would read one count short.

Clear timing is probed at the exact cycle where the count equals the target and one cycle later. A design that cleared as it reached the target, rather than on the next enable, shortens every period by one.

Staged writes are read back between the low and high byte, where a design that updated the live value early shows the new low byte. Toggle, drive and keep actions are each checked across two passes of the compare value, which exposes an action that fires on every enable rather than only on stepping onto the compare value.

// File: rtl/periodic_cmp_timer.sv
module periodic_cmp_timer #(
  parameter int CW        = 10,
  parameter int SYS_DIV_W = 2,
  parameter int FH_A_W    = 4,
  parameter int FH_B_W    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       fh_tick,
  input  logic       tbc_tick,
  input  logic       ext_clk_pin,
  output logic       tmr_pin
);
  localparam int HW = CW - 8;

  logic          hold_q, run_q, init_q, inv_q, clr_cmp_q, out_q;
  logic [2:0]    src_q;
  logic [1:0]    act_q;
  logic [CW-1:0] cnt_q, cmpa_q, prd_q, cnt_nxt, clr_tgt;
  logic [7:0]    cmpa_lo_q, prd_lo_q;
  logic [SYS_DIV_W-1:0] sys_div_q;
  logic [FH_B_W-1:0]    fh_div_q;
  logic [2:0]    ext_q;
  logic          step_src, step, cmp_hit, run_rise;

  wire wr_ctla = reg_we && reg_addr == 3'd0;
  wire wr_ctlb = reg_we && reg_addr == 3'd1;
  wire ext_rise = ext_q[1] & ~ext_q[2];
  wire ext_fall = ~ext_q[1] & ext_q[2];

  assign run_rise = wr_ctla && reg_wdata[3] && !run_q;

  always_comb begin
    case (src_q)
      3'b000:  step_src = &sys_div_q;
      3'b001:  step_src = 1'b1;
      3'b010:  step_src = fh_tick && (&fh_div_q[FH_A_W-1:0]);
      3'b011:  step_src = fh_tick && (&fh_div_q);
      3'b100,
      3'b101:  step_src = tbc_tick;
      3'b110:  step_src = ext_rise;
      default: step_src = ext_fall;
    endcase
  end

  assign step    = run_q && !hold_q && step_src;
  assign clr_tgt = clr_cmp_q ? cmpa_q : prd_q;
  assign cnt_nxt = (cnt_q == clr_tgt) ? '0 : cnt_q + 1'b1;
  assign cmp_hit = step && (cnt_nxt == cmpa_q);
  assign tmr_pin = out_q ^ inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_div_q <= '0;
      fh_div_q  <= '0;
      ext_q     <= '0;
    end else begin
      sys_div_q <= sys_div_q + 1'b1;
      if (fh_tick) fh_div_q <= fh_div_q + 1'b1;
      ext_q <= {ext_q[1], ext_q[0], ext_clk_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0; src_q <= '0; run_q <= 1'b0;
      act_q <= '0; init_q <= 1'b0; inv_q <= 1'b0; clr_cmp_q <= 1'b0;
    end else if (wr_ctla) begin
      hold_q <= reg_wdata[7]; src_q <= reg_wdata[6:4]; run_q <= reg_wdata[3];
    end else if (wr_ctlb) begin
      act_q <= reg_wdata[5:4]; init_q <= reg_wdata[3];
      inv_q <= reg_wdata[2]; clr_cmp_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpa_lo_q <= '0; prd_lo_q <= '0; cmpa_q <= '0; prd_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd4: cmpa_lo_q <= reg_wdata;
        3'd5: cmpa_q    <= {reg_wdata[HW-1:0], cmpa_lo_q};
        3'd6: prd_lo_q  <= reg_wdata;
        3'd7: prd_q     <= {reg_wdata[HW-1:0], prd_lo_q};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (run_rise) begin
      cnt_q <= '0;
      out_q <= init_q;
    end else if (step) begin
      cnt_q <= cnt_nxt;
      if (cmp_hit) begin
        case (act_q)
          2'b01:   out_q <= 1'b0;
          2'b10:   out_q <= 1'b1;
          2'b11:   out_q <= ~out_q;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {hold_q, src_q, run_q, 3'b000};
      3'd1:    reg_rdata = {2'b00, act_q, init_q, inv_q, 1'b0, clr_cmp_q};
      3'd2:    reg_rdata = cnt_q[7:0];
      3'd3:    reg_rdata = {{(8-HW){1'b0}}, cnt_q[CW-1:8]};
      3'd4:    reg_rdata = cmpa_q[7:0];
      3'd5:    reg_rdata = {{(8-HW){1'b0}}, cmpa_q[CW-1:8]};
      3'd6:    reg_rdata = prd_q[7:0];
      default: reg_rdata = {{(8-HW){1'b0}}, prd_q[CW-1:8]};
    endcase
  end

  AST_RUN_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $rose(run_q) |-> (cnt_q == '0 && out_q == init_q)); // R7
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!run_q && !$past(run_q)) |-> $stable(cnt_q)); // R8
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) $past(run_q && hold_q) |-> ($stable(cnt_q) && $stable(out_q))); // R9
  AST_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (!$stable(cnt_q) && $past(run_q)) |-> (cnt_q == CW'($past(cnt_q) + 1'b1) || cnt_q == '0)); // R10
  AST_CMPA_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cmpa_q) |-> $past(reg_we && reg_addr == 3'd5)); // R3
  AST_PRD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) !$stable(prd_q) |-> $past(reg_we && reg_addr == 3'd7)); // R3
  AST_PIN_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n) !$stable(out_q) |-> ($past(wr_ctla) || cnt_q == $past(cmpa_q))); // R11
endmodule

// File: tb/periodic_cmp_timer_tb.sv
module periodic_cmp_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, fh_tick = 1'b0, tbc_tick = 1'b0, ext_clk_pin = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic tmr_pin;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  periodic_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fh_tick(fh_tick),
    .tbc_tick(tbc_tick), .ext_clk_pin(ext_clk_pin), .tmr_pin(tmr_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {write addr, write data, read addr, expected read}
  localparam logic [21:0] VEC [8] = '{
    {3'd4, 8'h34, 3'd4, 8'h00},
    {3'd5, 8'h02, 3'd4, 8'h34},
    {3'd6, 8'hAB, 3'd5, 8'h02},
    {3'd7, 8'hFF, 3'd7, 8'h03},
    {3'd1, 8'hFF, 3'd1, 8'h3D},
    {3'd1, 8'h00, 3'd6, 8'hAB},
    {3'd0, 8'h0F, 3'd0, 8'h08},
    {3'd0, 8'h70, 3'd0, 8'h70}
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rdcnt(output int c);
    logic [7:0] lo, hi;
    rd(3'd2, lo); rd(3'd3, hi);
    c = {hi[1:0], lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  initial begin
    logic [7:0] d;
    int c0, c1;
    idle(2);
    chk("R1 pin after reset", tmr_pin, 0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1 reset read", d, 0);
    end
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][21:19], VEC[i][18:11]);
      rd(VEC[i][10:8], d);
      chk("R1 R2 R3 table", d, VEC[i][7:0]);
    end

    // every-cycle source, period 5, compare 3
    wr(3'd6, 8'd5); wr(3'd7, 8'd0); wr(3'd4, 8'd3); wr(3'd5, 8'd0);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h18);
    rdcnt(c0); chk("R7 on clears", c0, 0);
    idle(3); rdcnt(c0); chk("R4 every cycle", c0, 3);
    idle(2); rdcnt(c0); chk("R10 holds at period", c0, 5);
    idle(1); rdcnt(c0); chk("R10 period clear", c0, 0);
    idle(2);
    wr(3'd0, 8'h98);
    rdcnt(c0); chk("R9 pause write", c0, 3);
    idle(4); rdcnt(c0); chk("R9 paused hold", c0, 3);
    wr(3'd0, 8'h18);
    rdcnt(c0); chk("R9 unpause", c0, 3);
    idle(1); rdcnt(c0); chk("R9 resume", c0, 4);
    wr(3'd0, 8'h10);
    rdcnt(c0); chk("R8 off write", c0, 5);
    idle(5); rdcnt(c0); chk("R8 off retains", c0, 5);
    wr(3'd0, 8'h18);
    rdcnt(c0); chk("R7 on from off clears", c0, 0);

    // long period for rate checks
    wr(3'd6, 8'hFF); wr(3'd7, 8'h03);
    wr(3'd0, 8'h08);
    rdcnt(c0); idle(8); rdcnt(c1); chk("R4 sys/4 rate", c1 - c0, 2);
    wr(3'd0, 8'h28);
    rdcnt(c0); idle(10); rdcnt(c1); chk("R5 no ticks", c1 - c0, 0);
    fh_tick = 1'b1; idle(32); fh_tick = 1'b0;
    rdcnt(c1); chk("R5 fast/16", c1 - c0, 2);
    wr(3'd0, 8'h38);
    rdcnt(c0); fh_tick = 1'b1; idle(128); fh_tick = 1'b0;
    rdcnt(c1); chk("R5 fast/64", c1 - c0, 2);
    wr(3'd0, 8'h48);
    rdcnt(c0);
    for (int i = 0; i < 5; i++) begin tbc_tick = 1'b1; idle(1); tbc_tick = 1'b0; idle(1); end
    rdcnt(c1); chk("R5 time-base 100", c1 - c0, 5);
    wr(3'd0, 8'h58);
    rdcnt(c0);
    for (int i = 0; i < 3; i++) begin tbc_tick = 1'b1; idle(1); tbc_tick = 1'b0; idle(1); end
    rdcnt(c1); chk("R5 time-base 101", c1 - c0, 3);
    wr(3'd0, 8'h68);
    rdcnt(c0);
    for (int i = 0; i < 3; i++) begin ext_clk_pin = 1'b1; idle(4); ext_clk_pin = 1'b0; idle(4); end
    rdcnt(c1); chk("R6 rising edges", c1 - c0, 3);
    wr(3'd0, 8'h78);
    rdcnt(c0);
    for (int i = 0; i < 3; i++) begin ext_clk_pin = 1'b1; idle(4); ext_clk_pin = 1'b0; idle(4); end
    rdcnt(c1); chk("R6 falling edges", c1 - c0, 3);

    // compare output, compare 3, period 9
    wr(3'd4, 8'd3); wr(3'd5, 8'd0); wr(3'd6, 8'd9); wr(3'd7, 8'd0);
    wr(3'd0, 8'h10); wr(3'd1, 8'h30); wr(3'd0, 8'h18);
    chk("R7 starting level low", tmr_pin, 0);
    idle(2); chk("R11 before compare", tmr_pin, 0);
    idle(1); chk("R11 toggle first", tmr_pin, 1);
    idle(10); chk("R11 toggle second", tmr_pin, 0);
    wr(3'd1, 8'h34); chk("R11 invert", tmr_pin, 1);

    wr(3'd0, 8'h10); wr(3'd1, 8'h18); wr(3'd0, 8'h18);
    chk("R7 starting level high", tmr_pin, 1);
    idle(3); chk("R11 drive low", tmr_pin, 0);

    wr(3'd0, 8'h10); wr(3'd1, 8'h20); wr(3'd0, 8'h18);
    idle(3); chk("R11 drive high", tmr_pin, 1);
    idle(10); chk("R11 drive high again", tmr_pin, 1);

    wr(3'd0, 8'h10); wr(3'd1, 8'h08); wr(3'd0, 8'h18);
    idle(13); chk("R11 keep", tmr_pin, 1);

    wr(3'd0, 8'h10); wr(3'd1, 8'h01); wr(3'd0, 8'h18);
    idle(3); rdcnt(c0); chk("R10 at compare", c0, 3);
    idle(1); rdcnt(c0); chk("R10 compare clear", c0, 0);

    summary();
  end
endmodule